// File: doc/BRIEF.md
# Lockstep Three-Stage Transform Pipeline

This block pushes a stream of 16-bit words through three small arithmetic transforms. The first transform adds one. The second doubles the value and keeps the low bits. The third XORs the value with a fixed key. Two registers sit between the stages, and each one carries a presence flag. Words enter through a small input FIFO with a valid/ready handshake and leave through a small output FIFO with the same kind of handshake.

All stages step together. On every step, stage one takes a word from the input FIFO when one is waiting. When none is waiting, it inserts an empty slot instead. Empty slots travel down the pipe like data, but they never reach the output FIFO. The whole pipe freezes only when both of these hold: the output FIFO has no room, and the last register holds a real word. If the last register is empty, the pipe keeps stepping even while the output FIFO is full.

Top module: `lockstep_pipe`

## Requirements
- R1: While reset is held, and on the cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` drops to 0 once the input FIFO holds QD (default 4) words, and no word is taken while it is 0.
- R3: Every accepted word x leaves exactly once, in arrival order, as `((((x+1)*2) mod 2^16) ^ 16'hA5A5)`. Gaps in input and stalls on output do not change this.
- R4: When the pipe and both FIFOs are empty, a word accepted at clock edge E appears on `out_valid`/`out_data` right after edge E+3, and not before.
- R5: Empty slots never produce output. Once all accepted words have been delivered, `out_valid` stays 0 for as long as no new input arrives.
- R6: When the output FIFO is full and the last register holds a word, no stage register or presence flag changes. With `out_ready` held at 0 and input offered on every cycle, exactly 2*QD+2 words (10 by default) are accepted before `in_ready` stays 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R8: When the output FIFO is full but the last register is empty, the pipe still steps. With QD words already waiting in a full output FIFO and the pipe empty, exactly QD+2 more words (6 by default) are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input FIFO can take a word |
| in_data | input | W (16) | Input word |
| out_valid | output | 1 | Output FIFO holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W (16) | Oldest result |

## Verification
The hardest case to reach is R8: the output FIFO is full while the last pipeline register is empty. It only happens after the pipe has fully drained into a blocked output FIFO. The bench holds `out_ready` at 0, feeds exactly QD words, and idles until they have all settled in the output FIFO. It then offers input on every cycle and counts how many words are accepted. The count must be QD+2, not QD, which shows that stages one and two still moved. Separately, the full stall of R6 is reached by offering input continuously against a blocked output, which fills every stage register and both FIFOs.

// File: rtl/lockstep_pipe.sv
module lockstep_pipe #(
  parameter int W = 16,
  parameter int QD = 4,
  parameter logic [W-1:0] KEY = 16'hA5A5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (QD > 1) ? $clog2(QD) : 1;
  localparam int CW = $clog2(QD + 1);
  localparam logic [AW-1:0] LAST = AW'(QD - 1);

  logic [W-1:0]  iq_mem [QD];
  logic [AW-1:0] iq_wp, iq_rp;
  logic [CW-1:0] iq_cnt;
  logic [W-1:0]  oq_mem [QD];
  logic [AW-1:0] oq_wp, oq_rp;
  logic [CW-1:0] oq_cnt;
  logic [W-1:0]  r1, r2;
  logic          v1, v2;

  logic iq_push, iq_pop, oq_push, oq_pop, oq_full, adv;

  assign in_ready  = iq_cnt != CW'(QD);
  assign out_valid = oq_cnt != '0;
  assign out_data  = oq_mem[oq_rp];
  assign oq_full   = oq_cnt == CW'(QD);
  assign adv       = !oq_full || !v2;
  assign iq_push   = in_valid && in_ready;
  assign iq_pop    = adv && iq_cnt != '0;
  assign oq_push   = adv && v2;
  assign oq_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (iq_push) iq_mem[iq_wp] <= in_data;
    if (oq_push) oq_mem[oq_wp] <= r2 ^ KEY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iq_wp <= '0; iq_rp <= '0; iq_cnt <= '0;
      oq_wp <= '0; oq_rp <= '0; oq_cnt <= '0;
    end else begin
      if (iq_push) iq_wp <= (iq_wp == LAST) ? '0 : iq_wp + AW'(1);
      if (iq_pop)  iq_rp <= (iq_rp == LAST) ? '0 : iq_rp + AW'(1);
      iq_cnt <= iq_cnt + CW'(iq_push) - CW'(iq_pop);
      if (oq_push) oq_wp <= (oq_wp == LAST) ? '0 : oq_wp + AW'(1);
      if (oq_pop)  oq_rp <= (oq_rp == LAST) ? '0 : oq_rp + AW'(1);
      oq_cnt <= oq_cnt + CW'(oq_push) - CW'(oq_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (adv) begin
      v1 <= iq_cnt != '0;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      if (iq_cnt != '0) r1 <= iq_mem[iq_rp] + W'(1);
      r2 <= {r1[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/lockstep_pipe_chk.sv
module lockstep_pipe_chk #(
  parameter int W = 16,
  parameter int QD = 4,
  parameter int CW = $clog2(QD + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic          v1,
  input logic          v2,
  input logic [W-1:0]  r1,
  input logic [W-1:0]  r2,
  input logic [CW-1:0] iq_cnt,
  input logic [CW-1:0] oq_cnt
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && in_ready);

  assert_inq_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_cnt <= CW'(QD)) && (in_ready == (iq_cnt != CW'(QD))));

  assert_valid_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oq_cnt != CW'(QD) || !v2) |=> v2 == $past(v1));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oq_cnt == CW'(QD) && v2) |=> $stable(v1) && $stable(v2) && $stable(r1) && $stable(r2));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));

  assert_step_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oq_cnt == CW'(QD) && !v2 && iq_cnt != '0) |=> v1);
endmodule

bind lockstep_pipe lockstep_pipe_chk #(.W(W), .QD(QD)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .v1(v1), .v2(v2),
  .r1(r1), .r2(r2), .iq_cnt(iq_cnt), .oq_cnt(oq_cnt)
);

// File: tb/sim_lockstep_pipe.sv
module sim_lockstep_pipe;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic [15:0] out_data;
  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  logic [15:0] seed_val = 16'h0100;

  always #4 clk = ~clk;

  lockstep_pipe u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [15:0] xf(input logic [15:0] x);
    logic [15:0] t;
    t = x + 16'd1;
    t = {t[14:0], 1'b0};
    return t ^ 16'hA5A5;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) exp_q.push_back(xf(in_data));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R3 extra output", {16'h0, out_data}, 32'hFFFF_FFFF);
        else check(out_data == exp_q[0], "R3 value/order", {16'h0, out_data}, {16'h0, exp_q[0]});
        if (exp_q.size() != 0) void'(exp_q.pop_front());
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic feed(input int cycles, output int accepted);
    bit acc;
    accepted = 0;
    in_valid = 1'b1; in_data = seed_val;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); acc = in_ready;
      step();
      if (acc) begin accepted++; seed_val++; in_data = seed_val; end
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    repeat (30) step();
    check(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    step();
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after release", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic t_latency();
    out_ready = 1'b1;
    in_valid = 1'b1; in_data = 16'd5;
    step();
    in_valid = 1'b0;
    step(); step();
    @(negedge clk);
    check(out_valid == 1'b0, "R4 early", out_valid, 0);
    step();
    @(negedge clk);
    check(out_valid == 1'b1, "R4 on time", out_valid, 1);
    check(out_data == 16'hA5A9, "R4 data", out_data, 16'hA5A9);
    drain();
  endtask

  task automatic t_bubbles();
    bit seen = 0;
    out_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (out_valid) seen = 1;
      step();
    end
    check(!seen, "R5 no output from bubbles", seen, 0);
  endtask

  task automatic t_stall();
    int acc;
    logic [15:0] held;
    out_ready = 1'b0;
    feed(30, acc);
    check(acc == 10, "R6 stall capacity", acc, 10);
    @(negedge clk);
    check(in_ready == 1'b0, "R2 in_ready low when full", in_ready, 0);
    held = out_data;
    repeat (3) step();
    @(negedge clk);
    check(out_valid && out_data == held, "R7 output held", {15'h0, out_valid, out_data}, {16'h1, held});
    drain();
  endtask

  task automatic t_free_last();
    int acc;
    out_ready = 1'b0;
    feed(4, acc);
    repeat (10) step();
    feed(30, acc);
    check(acc == 6, "R8 steps with empty last stage", acc, 6);
    drain();
  endtask

  task automatic t_random();
    bit acc;
    in_valid = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); acc = in_valid && in_ready;
      step();
      out_ready = ($urandom % 3) != 0;
      if (acc || !in_valid) begin
        if (acc) seed_val = seed_val + 16'd7;
        in_valid = ($urandom % 2) != 0;
        in_data = seed_val ^ 16'(($urandom) & 16'hFF00);
      end
    end
    in_valid = 1'b0;
    drain();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) step();
    t_reset();
    t_latency();
    t_bubbles();
    t_stall();
    t_free_last();
    t_random();
    t_bubbles();
    report();
  end
endmodule